// File: doc/BRIEF.md
# PLL Configuration Go Sequencer

This block applies a new configuration to a phase-locked loop and then starts the loop's locking sequence. Software first writes a configuration word and then sets a GO bit. On an accepted GO, the block copies the configuration into a shadow register. It then drives three control lines in a fixed order: an active-low initialise line, an enable line, and a divider-enable line. The divider-enable line also loads the high-speed output divider, so the divider settings and the loop settings take effect in the same sequence. The GO bit clears by itself once the sequence has finished.

A mode bit selects when the sequence runs.

- **Manual mode (0):** the sequence starts in the cycle after GO is set. The clock-input-enable, divider-bypass and reference-enable outputs follow the software bits.
- **Automatic mode (1):** the block waits for a front-porch strobe from the display controller. Both the sequence and the transfer of the shadow into the loop's applied configuration happen at that strobe. The block also drives clock-input-enable, bypass and reference-enable itself, and ignores the software bits for those outputs.

Top module: `pll_go_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, go_bit, busy, pll_en and pll_div_en are 0, pll_init_n is 1, and shadow_cfg and pll_cfg are all zeros.
- R2: A go_set pulse while idle makes go_bit and busy 1 from the next clock edge. Both stay 1 until the clock edge that ends the last divider-enable cycle, where they return to 0.
- R3: Once the sequence starts, the outputs follow this order:
  - pll_init_n is 0 for N_INIT cycles, with pll_en and pll_div_en at 0.
  - pll_init_n returns to 1 and pll_en is 1 for N_EN cycles, with pll_div_en at 0.
  - pll_div_en is 1 for N_DIV cycles, with pll_en still at 1.
  - pll_en stays 1 after the sequence ends.
- R4: In automatic mode (mode_auto = 1), the sequence does not start until a fp_strobe cycle. Until then, pll_init_n stays 1 and busy stays 1. The clock edge that samples the strobe starts the N_INIT phase.
- R5: pll_cfg takes a new value only when the sequence starts.
  - In manual mode it takes the configuration register at the GO edge.
  - In automatic mode it takes the shadow at the strobe edge, so configuration writes made after GO do not reach it.
- R6: An accepted GO copies the configuration register into shadow_cfg in both modes.
- R7: A go_set while busy is ignored. The shadow keeps its value and the sequence timing does not change, even if new configuration data was written.
- R8: A fp_strobe while busy is 0 has no effect. busy stays 0, pll_init_n stays 1, and pll_cfg stays unchanged.
- R9: In manual mode, clkin_en, hsdiv_bypass and ref_en equal sw_clkin_en, sw_bypass and sw_ref_en.
- R10: In automatic mode, the software bits are ignored for these outputs:
  - hsdiv_bypass is 1 and clkin_en is 0 while busy is 1.
  - hsdiv_bypass is 0 and clkin_en is 1 once busy is 0.
  - ref_en is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 24 | Configuration word: multiplier [23:13], pre-divider [12:5], high-speed divider [4:0] |
| go_set | input | 1 | Software write of 1 to the GO bit |
| mode_auto | input | 1 | Trigger mode: 0 manual, 1 automatic |
| fp_strobe | input | 1 | Front-porch strobe from the display controller |
| sw_clkin_en | input | 1 | Software clock-input-enable bit |
| sw_bypass | input | 1 | Software divider-bypass bit |
| sw_ref_en | input | 1 | Software reference-enable bit |
| go_bit | output | 1 | GO bit as read back by software |
| busy | output | 1 | High from an accepted GO until GO clears |
| shadow_cfg | output | 24 | Shadow copy of the configuration |
| pll_cfg | output | 24 | Configuration applied to the loop |
| pll_init_n | output | 1 | Active-low initialise to the loop |
| pll_en | output | 1 | Loop enable |
| pll_div_en | output | 1 | Divider-enable, shared with the output divider |
| clkin_en | output | 1 | Clock-input enable to the loop |
| hsdiv_bypass | output | 1 | Output divider bypass |
| ref_en | output | 1 | Reference enable |

## Verification
The bench writes new configuration data and a second GO in the middle of a running sequence. A design that accepted the second GO would refresh the shadow or restart the init phase, and the cycle-by-cycle trace would show it. In automatic mode, the bench writes new configuration data between GO and the strobe. A design that loaded the loop from the live register instead of the shadow, or loaded it at GO, would show the wrong pll_cfg. Strobes sent while idle must start nothing. The software override bits change randomly every cycle, so a mux that leaked them through in automatic mode would mismatch.

// File: rtl/pll_go_pkg.sv
package pll_go_pkg;

    localparam int MULT_W = 11;
    localparam int PDIV_W = 8;
    localparam int HDIV_W = 5;

    typedef struct packed {
        logic [MULT_W-1:0] mult;
        logic [PDIV_W-1:0] prediv;
        logic [HDIV_W-1:0] hsdiv;
    } pll_cfg_t;

    localparam int CFG_W = $bits(pll_cfg_t);

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT_FP,
        S_INIT,
        S_EN,
        S_DIV
    } seq_state_t;

    typedef struct packed {
        logic clkin_en;
        logic bypass;
        logic ref_en;
    } ovr_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pll_go_fsm.sv
module pll_go_fsm
    import pll_go_pkg::*;
#(
    parameter int N_INIT = 3,
    parameter int N_EN   = 4,
    parameter int N_DIV  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic go_set,
    input  logic mode_auto,
    input  logic fp_strobe,
    output logic go_bit,
    output logic go_accept,
    output logic load_now,
    output logic load_shadow,
    output logic init_n,
    output logic en,
    output logic div_en
);

    localparam int CNT_W = cnt_width(max3(N_INIT, N_EN, N_DIV));
    localparam logic [CNT_W-1:0] LAST_INIT = CNT_W'(N_INIT - 1);
    localparam logic [CNT_W-1:0] LAST_EN   = CNT_W'(N_EN - 1);
    localparam logic [CNT_W-1:0] LAST_DIV  = CNT_W'(N_DIV - 1);

    seq_state_t       st, st_nx;
    logic [CNT_W-1:0] cnt;
    logic             en_q;
    logic             fp_start;
    logic             phase_end;

    always_comb begin
        go_accept = (st == S_IDLE) && go_set;
        fp_start  = (st == S_WAIT_FP) && fp_strobe;
        unique case (st)
            S_INIT:  phase_end = (cnt == LAST_INIT);
            S_EN:    phase_end = (cnt == LAST_EN);
            S_DIV:   phase_end = (cnt == LAST_DIV);
            default: phase_end = 1'b0;
        endcase
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:    if (go_accept) st_nx = mode_auto ? S_WAIT_FP : S_INIT;
            S_WAIT_FP: if (fp_start)  st_nx = S_INIT;
            S_INIT:    if (phase_end) st_nx = S_EN;
            S_EN:      if (phase_end) st_nx = S_DIV;
            S_DIV:     if (phase_end) st_nx = S_IDLE;
            default:   st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= S_IDLE;
            cnt  <= '0;
            en_q <= 1'b0;
        end else begin
            st  <= st_nx;
            cnt <= (st_nx != st) ? '0 : cnt + 1'b1;
            if (st_nx == S_INIT && st != S_INIT)
                en_q <= 1'b0;
            else if (st == S_INIT && st_nx == S_EN)
                en_q <= 1'b1;
        end
    end

    assign go_bit      = (st != S_IDLE);
    assign load_now    = go_accept && !mode_auto;
    assign load_shadow = fp_start;
    assign init_n      = (st != S_INIT);
    assign en          = en_q;
    assign div_en      = (st == S_DIV);

    p_go_ends_after_div_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(go_bit) |-> $past(div_en));
    p_init_excludes_en_r3: assert property (@(posedge clk) disable iff (rst)
        !init_n |-> !en);
    p_div_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
        div_en |-> en);
    p_wait_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (st == S_WAIT_FP && !fp_strobe) |=> (st == S_WAIT_FP));
    p_busy_go_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (st inside {S_INIT, S_EN, S_DIV}) |=> (st != S_WAIT_FP));
    p_idle_fp_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE && !go_set && fp_strobe) |=> (st == S_IDLE));

endmodule

// File: rtl/pll_go_cfg.sv
module pll_go_cfg
    import pll_go_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cfg_wr,
    input  pll_cfg_t cfg_wdata,
    input  logic     go_bit,
    input  logic     go_accept,
    input  logic     load_now,
    input  logic     load_shadow,
    output pll_cfg_t shadow_q,
    output pll_cfg_t applied_q
);

    pll_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            shadow_q  <= '0;
            applied_q <= '0;
        end else begin
            if (cfg_wr)      cfg_q     <= cfg_wdata;
            if (go_accept)   shadow_q  <= cfg_q;
            if (load_now)    applied_q <= cfg_q;
            else if (load_shadow) applied_q <= shadow_q;
        end
    end

    p_shadow_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (go_bit && $past(go_bit)) |-> $stable(shadow_q));
    p_applied_only_at_start_r5: assert property (@(posedge clk) disable iff (rst)
        (!load_now && !load_shadow) |=> $stable(applied_q));

endmodule

// File: rtl/pll_go_ovr.sv
module pll_go_ovr
    import pll_go_pkg::*;
(
    input  logic mode_auto,
    input  logic busy,
    input  ovr_t sw,
    output ovr_t drv
);

    always_comb begin
        if (mode_auto) begin
            drv.clkin_en = !busy;
            drv.bypass   = busy;
            drv.ref_en   = 1'b1;
        end else begin
            drv = sw;
        end
    end

endmodule

// File: rtl/pll_go_seq.sv
module pll_go_seq
    import pll_go_pkg::*;
#(
    parameter int N_INIT = 3,
    parameter int N_EN   = 4,
    parameter int N_DIV  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             go_set,
    input  logic             mode_auto,
    input  logic             fp_strobe,
    input  logic             sw_clkin_en,
    input  logic             sw_bypass,
    input  logic             sw_ref_en,
    output logic             go_bit,
    output logic             busy,
    output logic [CFG_W-1:0] shadow_cfg,
    output logic [CFG_W-1:0] pll_cfg,
    output logic             pll_init_n,
    output logic             pll_en,
    output logic             pll_div_en,
    output logic             clkin_en,
    output logic             hsdiv_bypass,
    output logic             ref_en
);

    logic     go_q, go_accept, load_now, load_shadow;
    pll_cfg_t shadow_s, applied_s;
    ovr_t     sw_s, drv_s;

    pll_go_fsm #(.N_INIT(N_INIT), .N_EN(N_EN), .N_DIV(N_DIV)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .go_set      (go_set),
        .mode_auto   (mode_auto),
        .fp_strobe   (fp_strobe),
        .go_bit      (go_q),
        .go_accept   (go_accept),
        .load_now    (load_now),
        .load_shadow (load_shadow),
        .init_n      (pll_init_n),
        .en          (pll_en),
        .div_en      (pll_div_en)
    );

    pll_go_cfg u_cfg (
        .clk         (clk),
        .rst         (rst),
        .cfg_wr      (cfg_wr),
        .cfg_wdata   (pll_cfg_t'(cfg_wdata)),
        .go_bit      (go_q),
        .go_accept   (go_accept),
        .load_now    (load_now),
        .load_shadow (load_shadow),
        .shadow_q    (shadow_s),
        .applied_q   (applied_s)
    );

    assign sw_s = '{clkin_en: sw_clkin_en, bypass: sw_bypass, ref_en: sw_ref_en};

    pll_go_ovr u_ovr (
        .mode_auto (mode_auto),
        .busy      (go_q),
        .sw        (sw_s),
        .drv       (drv_s)
    );

    assign go_bit       = go_q;
    assign busy         = go_q;
    assign shadow_cfg   = shadow_s;
    assign pll_cfg      = applied_s;
    assign clkin_en     = drv_s.clkin_en;
    assign hsdiv_bypass = drv_s.bypass;
    assign ref_en       = drv_s.ref_en;

    p_auto_bypass_in_init_r10: assert property (@(posedge clk) disable iff (rst)
        (mode_auto && !pll_init_n) |-> (hsdiv_bypass && !clkin_en && ref_en));
    p_divider_only_when_busy_r2: assert property (@(posedge clk) disable iff (rst)
        pll_div_en |-> busy);

endmodule

// File: tb/test_pll_go_seq.sv
module test_pll_go_seq;
    import pll_go_pkg::*;

    localparam int NI = 3;
    localparam int NE = 4;
    localparam int ND = 2;
    localparam int T  = NI + NE + ND;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_wr = 1'b0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic             go_set = 1'b0;
    logic             mode_auto = 1'b0;
    logic             fp_strobe = 1'b0;
    logic             sw_clkin_en = 1'b0, sw_bypass = 1'b0, sw_ref_en = 1'b0;
    logic             go_bit, busy, pll_init_n, pll_en, pll_div_en;
    logic             clkin_en, hsdiv_bypass, ref_en;
    logic [CFG_W-1:0] shadow_cfg, pll_cfg;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pll_go_seq #(.N_INIT(NI), .N_EN(NE), .N_DIV(ND)) i_pll_go_seq (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .go_set(go_set), .mode_auto(mode_auto), .fp_strobe(fp_strobe),
        .sw_clkin_en(sw_clkin_en), .sw_bypass(sw_bypass), .sw_ref_en(sw_ref_en),
        .go_bit(go_bit), .busy(busy), .shadow_cfg(shadow_cfg), .pll_cfg(pll_cfg),
        .pll_init_n(pll_init_n), .pll_en(pll_en), .pll_div_en(pll_div_en),
        .clkin_en(clkin_en), .hsdiv_bypass(hsdiv_bypass), .ref_en(ref_en)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {init_n, en, div_en} expected at sample k after the sequence starts
    function automatic logic [2:0] exp_ctl(input int k);
        if (k <= NI)           return 3'b000;
        else if (k <= NI + NE) return 3'b110;
        else if (k <= T)       return 3'b111;
        else                   return 3'b110;
    endfunction

    task automatic rand_sw();
        sw_clkin_en = 1'($urandom);
        sw_bypass   = 1'($urandom);
        sw_ref_en   = 1'($urandom);
    endtask

    task automatic chk_ovr(input logic auto_m, input logic bsy);
        if (auto_m) begin
            chk("R10 bypass", hsdiv_bypass, bsy);
            chk("R10 clkin_en", clkin_en, !bsy);
            chk("R10 ref_en", ref_en, 1'b1);
        end else begin
            chk("R9 overrides", {clkin_en, hsdiv_bypass, ref_en},
                {sw_clkin_en, sw_bypass, sw_ref_en});
        end
    endtask

    task automatic run_seq(input logic auto_m, input logic [CFG_W-1:0] c,
                           input int fp_wait, input logic dbl_go);
        logic [CFG_W-1:0] prev_pll;
        prev_pll = pll_cfg;
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = c; mode_auto = auto_m; rand_sw();
        @(negedge clk);
        cfg_wr = 1'b0; go_set = 1'b1;
        @(posedge clk); #1;
        chk("R2 busy after GO", {go_bit, busy}, 2'b11);
        chk("R6 shadow loaded", shadow_cfg, c);
        if (auto_m) begin
            for (int d = 0; d < fp_wait; d++) begin
                chk("R4 init held while waiting", {pll_init_n, busy, pll_div_en}, 3'b110);
                chk("R5 pll_cfg unchanged before strobe", pll_cfg, prev_pll);
                chk_ovr(auto_m, 1'b1);
                @(negedge clk);
                go_set    = dbl_go && (d == 1);
                cfg_wr    = (d == 0);
                cfg_wdata = ~c;
                fp_strobe = (d == fp_wait - 1);
                rand_sw();
                @(posedge clk); #1;
            end
            chk("R7 shadow kept after late write", shadow_cfg, c);
        end
        chk("R5 pll_cfg at start", pll_cfg, c);
        for (int k = 1; k <= T + 1; k++) begin
            chk("R3 control order", {pll_init_n, pll_en, pll_div_en}, exp_ctl(k));
            chk("R2 busy span", {go_bit, busy}, (k <= T) ? 2'b11 : 2'b00);
            chk("R7 shadow stable", shadow_cfg, c);
            chk("R5 pll_cfg held", pll_cfg, c);
            chk_ovr(auto_m, k <= T);
            if (k <= T) begin
                @(negedge clk);
                go_set    = dbl_go && (k == 2);
                cfg_wr    = dbl_go && (k == 2);
                cfg_wdata = c ^ {CFG_W{1'b1}};
                fp_strobe = 1'b0;
                rand_sw();
                @(posedge clk); #1;
            end
        end
        @(negedge clk);
        go_set = 1'b0; cfg_wr = 1'b0; fp_strobe = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog expired: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [CFG_W-1:0] keep;
        void'($urandom(32'd20240));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset outputs", {go_bit, busy, pll_init_n, pll_en, pll_div_en}, 5'b00100);
        chk("R1 reset shadow", shadow_cfg, '0);
        chk("R1 reset pll_cfg", pll_cfg, '0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk("R1 after reset", {go_bit, busy, pll_init_n, pll_en, pll_div_en}, 5'b00100);

        // directed corner cases
        run_seq(1'b0, 24'h5A5A5A, 0, 1'b0);
        run_seq(1'b0, 24'h123456, 0, 1'b1);
        run_seq(1'b1, 24'h0F0F0F, 1, 1'b0);
        run_seq(1'b1, 24'hABCDEF, 5, 1'b1);

        // R8: strobes while idle start nothing
        keep = pll_cfg;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            fp_strobe = 1'b1; mode_auto = 1'(i);
            @(posedge clk); #1;
            @(negedge clk); fp_strobe = 1'b0;
            @(posedge clk); #1;
            chk("R8 idle strobe ignored", {busy, pll_init_n, pll_div_en}, 3'b010);
            chk("R8 pll_cfg unchanged", pll_cfg, keep);
        end

        // random mix
        for (int n = 0; n < 30; n++) begin
            run_seq(1'($urandom), CFG_W'($urandom), 1 + int'($urandom % 6), 1'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule